// File: doc/BRIEF.md
# Display Window Setup and Pixel Streamer

This block drives an 8080-style parallel write bus to a display controller once that controller has been initialised. A caller hands it a drawing rectangle (first and last column, first and last row, each 16 bits). The block frames that rectangle as three commands on the bus: the column range, then the row range, then the start of memory writing. After that it accepts a stream of pixels on a valid/ready handshake and writes each pixel to the bus as panel data.

Each pixel carries a format tag: 16-bit 5-6-5, 18-bit packed 6-6-6, or 24-bit 8-8-8. A mode input selects the panel bus depth. In 16-bit mode every pixel is one 5-6-5 word. In 18-bit mode every pixel takes two writes, and a 5-6-5 source is widened by repeating the top bit of each 5-bit channel. The stream has no pixel count. It lasts while the caller holds an active input high. A window request that arrives during a stream is kept and started once the stream ends.

Top module: `lcd_win_streamer`

## Requirements
- R1: After a window request is accepted, the first five bus writes are: command 0x2A, then as data the high byte of the first column, its low byte, the high byte of the last column, and its low byte. Each byte is carried in bits 7:0 of the bus with bits 15:8 zero.
- R2: Next come command 0x2B and four data writes: first-row high, first-row low, last-row high, last-row low. Then comes command 0x2C. Every later write up to the end of the stream is pixel data.
- R3: In 16-bit mode, an 8-8-8 pixel (red 23:16, green 15:8, blue 7:0) or a packed 6-6-6 pixel (red 17:12, green 11:6, blue 5:0) is written as one word. The word holds the top 5 red bits in 15:11, the top 6 green bits in 10:5 and the top 5 blue bits in 4:0.
- R4: In 16-bit mode, a 5-6-5 pixel (format tag 0; tags are 0 = 5-6-5, 1 = 6-6-6, 2 = 8-8-8) is written unchanged as one word.
- R5: In 18-bit mode, each pixel takes exactly two writes. The first holds red in bits 15:10 and green in bits 7:2. The second holds blue in bits 7:2. All other bits are zero.
- R6: In 18-bit mode, an 8-8-8 pixel keeps the top 6 bits of each channel, and a 6-6-6 pixel is used as is.
- R7: In 18-bit mode, a 5-6-5 pixel forms 6-bit red and blue by appending each channel's own most significant bit below it. Green is passed through.
- R8: Command writes drive register-select low and data writes drive it high. An accepted pixel starts a data write on the next cycle.
- R9: Each write holds the strobe low for exactly LOW_CYC clock cycles. Data and register-select stay constant while the strobe is low.
- R10: pix_ready is low while the window commands are being written and while any write, including the second write of an 18-bit pixel, is in progress. It is high only while stream_on is high.
- R11: A window request made while the block is busy writes nothing until the current stream ends. Its rectangle is then framed as in R1 and R2.
- R12: Out of reset, and after stream_on falls with no write pending, the strobe is high and pix_ready is low. The bus mode is sampled when a window's command sequence begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode18 | input | 1 | Bus depth: 1 = 18-bit (two writes per pixel), 0 = 16-bit |
| win_req | input | 1 | One-cycle request to frame a new window |
| col_first | input | 16 | First column of the window |
| col_last | input | 16 | Last column of the window |
| row_first | input | 16 | First row of the window |
| row_last | input | 16 | Last row of the window |
| stream_on | input | 1 | High while the pixel stream is active; low ends it |
| pix_valid | input | 1 | Pixel present |
| pix_fmt | input | 2 | Pixel format tag: 0 = 5-6-5, 1 = 6-6-6, 2 = 8-8-8 |
| pix_data | input | 24 | Pixel value, aligned to bit 0 |
| pix_ready | output | 1 | Block accepts a pixel this cycle |
| lcd_rs | output | 1 | Register select: 0 = command, 1 = data |
| lcd_wr_n | output | 1 | Active-low write strobe |
| lcd_d | output | 16 | Bus data |

## Verification
The hardest case to reach from the ports is a window request that lands during a live stream. The bench opens a stream, pulses win_req with a second rectangle while pixels still flow, and watches that no command appears on the bus. It then drops stream_on and checks that the new rectangle's eleven writes follow. The 18-bit expansion is exercised with 5-6-5 pixels whose top channel bits are 1 in one case and 0 in another. The mode input is changed after the window starts, which shows that the sampled depth still governs the stream.

// File: rtl/lcd_win_streamer.sv
module lcd_win_streamer #(
  parameter int LOW_CYC  = 200,
  parameter int HIGH_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode18,
  input  logic        win_req,
  input  logic [15:0] col_first,
  input  logic [15:0] col_last,
  input  logic [15:0] row_first,
  input  logic [15:0] row_last,
  input  logic        stream_on,
  input  logic        pix_valid,
  input  logic [1:0]  pix_fmt,
  input  logic [23:0] pix_data,
  output logic        pix_ready,
  output logic        lcd_rs,
  output logic        lcd_wr_n,
  output logic [15:0] lcd_d
);
  localparam int TW = $clog2(LOW_CYC + HIGH_CYC + 1);
  localparam logic [3:0] LAST_IDX = 4'd10;

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_STRM} st_t;

  st_t          st;
  logic [3:0]   idx;
  logic [63:0]  cur, pend;
  logic         pend_v, m18;
  logic         wr_act, wr_lo, need2;
  logic [TW-1:0] tcnt;
  logic [15:0]  w2;
  logic         free;
  logic [16:0]  seq;
  logic [5:0]   r6, g6, b6;
  logic [15:0]  w16, w1_18, w2_18;

  assign free      = !wr_act || (!wr_lo && tcnt == '0);
  assign pix_ready = (st == S_STRM) && stream_on && !wr_act && !need2;

  always_comb begin
    case (idx)
      4'd0:    seq = {1'b0, 16'h002A};
      4'd1:    seq = {1'b1, 8'h00, cur[63:56]};
      4'd2:    seq = {1'b1, 8'h00, cur[55:48]};
      4'd3:    seq = {1'b1, 8'h00, cur[47:40]};
      4'd4:    seq = {1'b1, 8'h00, cur[39:32]};
      4'd5:    seq = {1'b0, 16'h002B};
      4'd6:    seq = {1'b1, 8'h00, cur[31:24]};
      4'd7:    seq = {1'b1, 8'h00, cur[23:16]};
      4'd8:    seq = {1'b1, 8'h00, cur[15:8]};
      4'd9:    seq = {1'b1, 8'h00, cur[7:0]};
      default: seq = {1'b0, 16'h002C};
    endcase
  end

  always_comb begin
    case (pix_fmt)
      2'd0: begin
        r6 = {pix_data[15:11], pix_data[15]};
        g6 = pix_data[10:5];
        b6 = {pix_data[4:0], pix_data[4]};
      end
      2'd1: begin
        r6 = pix_data[17:12];
        g6 = pix_data[11:6];
        b6 = pix_data[5:0];
      end
      default: begin
        r6 = pix_data[23:18];
        g6 = pix_data[15:10];
        b6 = pix_data[7:2];
      end
    endcase
  end

  assign w16   = {r6[5:1], g6, b6[5:1]};
  assign w1_18 = {r6, 2'b00, g6, 2'b00};
  assign w2_18 = {8'h00, b6, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      cur      <= '0;
      pend     <= '0;
      pend_v   <= 1'b0;
      m18      <= 1'b0;
      wr_act   <= 1'b0;
      wr_lo    <= 1'b0;
      need2    <= 1'b0;
      tcnt     <= '0;
      w2       <= '0;
      lcd_rs   <= 1'b1;
      lcd_wr_n <= 1'b1;
      lcd_d    <= '0;
    end else begin
      if (wr_act) begin
        if (wr_lo) begin
          if (tcnt == '0) begin
            wr_lo    <= 1'b0;
            lcd_wr_n <= 1'b1;
            tcnt     <= TW'(HIGH_CYC - 1);
          end else begin
            tcnt <= tcnt - 1'b1;
          end
        end else if (tcnt == '0) begin
          wr_act <= 1'b0;
        end else begin
          tcnt <= tcnt - 1'b1;
        end
      end

      case (st)
        S_IDLE: begin
          if (win_req) begin
            cur <= {col_first, col_last, row_first, row_last};
            m18 <= mode18;
            idx <= '0;
            st  <= S_CMD;
          end
        end
        S_CMD: begin
          if (free) begin
            wr_act   <= 1'b1;
            wr_lo    <= 1'b1;
            lcd_wr_n <= 1'b0;
            tcnt     <= TW'(LOW_CYC - 1);
            {lcd_rs, lcd_d} <= seq;
            idx <= idx + 1'b1;
            if (idx == LAST_IDX) st <= S_STRM;
          end
        end
        default: begin
          if (need2) begin
            if (free) begin
              wr_act   <= 1'b1;
              wr_lo    <= 1'b1;
              lcd_wr_n <= 1'b0;
              tcnt     <= TW'(LOW_CYC - 1);
              lcd_rs   <= 1'b1;
              lcd_d    <= w2;
              need2    <= 1'b0;
            end
          end else if (pix_valid && pix_ready) begin
            wr_act   <= 1'b1;
            wr_lo    <= 1'b1;
            lcd_wr_n <= 1'b0;
            tcnt     <= TW'(LOW_CYC - 1);
            lcd_rs   <= 1'b1;
            lcd_d    <= m18 ? w1_18 : w16;
            w2       <= w2_18;
            need2    <= m18;
          end else if (!stream_on && !wr_act) begin
            if (pend_v) begin
              cur    <= pend;
              m18    <= mode18;
              pend_v <= 1'b0;
              idx    <= '0;
              st     <= S_CMD;
            end else begin
              st <= S_IDLE;
            end
          end
        end
      endcase

      if (win_req && st != S_IDLE) begin
        pend   <= {col_first, col_last, row_first, row_last};
        pend_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcd_win_streamer_chk.sv
module lcd_win_streamer_chk #(
  parameter int LOW_CYC = 200
) (
  input logic        clk,
  input logic        rst_n,
  input logic        stream_on,
  input logic        pix_valid,
  input logic        pix_ready,
  input logic        lcd_rs,
  input logic        lcd_wr_n,
  input logic [15:0] lcd_d
);
  logic [15:0] lowcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowcnt <= '0;
    else if (!lcd_wr_n) lowcnt <= lowcnt + 1'b1;
    else lowcnt <= '0;
  end

  // R9
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_wr_n |=> (lcd_wr_n || ($stable(lcd_d) && $stable(lcd_rs))));

  // R9
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_wr_n) |-> lowcnt == 16'(LOW_CYC));

  // R10
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (lcd_wr_n && stream_on));

  // R8
  pixel_data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready) |=> (lcd_rs && !lcd_wr_n));
endmodule

bind lcd_win_streamer lcd_win_streamer_chk #(.LOW_CYC(LOW_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .stream_on(stream_on), .pix_valid(pix_valid),
  .pix_ready(pix_ready), .lcd_rs(lcd_rs), .lcd_wr_n(lcd_wr_n), .lcd_d(lcd_d));

// File: tb/test_lcd_win_streamer.sv
`timescale 1ns/100ps
module test_lcd_win_streamer;
  localparam int LOWC = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode18 = 1'b0, win_req = 1'b0, stream_on = 1'b0, pix_valid = 1'b0;
  logic [15:0] col_first = '0, col_last = '0, row_first = '0, row_last = '0;
  logic [1:0]  pix_fmt = '0;
  logic [23:0] pix_data = '0;
  logic pix_ready, lcd_rs, lcd_wr_n;
  logic [15:0] lcd_d;

  int checks = 0, errors = 0, width_bad = 0;
  logic [16:0] mon_q[$];
  logic prev_wr = 1'b1;
  int lowcnt = 0;

  always #2.5 clk = ~clk;

  lcd_win_streamer #(.LOW_CYC(LOWC), .HIGH_CYC(2)) i_lcd_win_streamer (.*);

  always @(negedge clk) begin
    if (!lcd_wr_n) lowcnt <= lowcnt + 1;
    if (rst_n && lcd_wr_n && !prev_wr) begin
      mon_q.push_back({lcd_rs, lcd_d});
      if (lowcnt != LOWC) width_bad <= width_bad + 1;
      lowcnt <= 0;
    end
    prev_wr <= lcd_wr_n;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_words(input int n);
    int t = 0;
    while (mon_q.size() < n && t < 2000) begin @(negedge clk); t++; end
  endtask

  task automatic chk_win(input string req, input logic [15:0] c1, c2, r1, r2);
    logic [16:0] exp[11];
    exp = '{17'h0002A, {9'h100, c1[15:8]}, {9'h100, c1[7:0]}, {9'h100, c2[15:8]}, {9'h100, c2[7:0]},
            17'h0002B, {9'h100, r1[15:8]}, {9'h100, r1[7:0]}, {9'h100, r2[15:8]}, {9'h100, r2[7:0]},
            17'h0002C};
    chk(mon_q.size() >= 11, req, mon_q.size(), 11);
    for (int i = 0; i < 11 && i < mon_q.size(); i++)
      chk(mon_q[i] == exp[i], req, mon_q[i], exp[i]);
  endtask

  task automatic open_window(input logic m, input logic [15:0] c1, c2, r1, r2);
    int rdy_seen = 0;
    mon_q.delete();
    @(negedge clk);
    mode18 = m; col_first = c1; col_last = c2; row_first = r1; row_last = r2;
    win_req = 1'b1; stream_on = 1'b1;
    @(negedge clk);
    win_req = 1'b0;
    while (mon_q.size() < 11) begin
      if (pix_ready) rdy_seen++;
      @(negedge clk);
    end
    chk(rdy_seen == 0, "R10 ready during commands", rdy_seen, 0);
  endtask

  task automatic send_pix(input logic [1:0] f, input logic [23:0] d, input int nw, input string req,
                          input logic [15:0] e1, input logic [15:0] e2);
    int t = 0, rdy_seen = 0;
    mon_q.delete();
    pix_fmt = f; pix_data = d; pix_valid = 1'b1;
    while (!pix_ready && t < 2000) begin @(negedge clk); t++; end
    @(negedge clk);
    pix_valid = 1'b0;
    t = 0;
    while (mon_q.size() < nw && t < 2000) begin
      if (pix_ready) rdy_seen++;
      @(negedge clk); t++;
    end
    repeat (6) @(negedge clk);
    chk(mon_q.size() == nw, req, mon_q.size(), nw);
    if (mon_q.size() >= 1) chk(mon_q[0] == {1'b1, e1}, req, mon_q[0], {1'b1, e1});
    if (nw == 2 && mon_q.size() >= 2) begin
      chk(mon_q[1] == {1'b1, e2}, req, mon_q[1], {1'b1, e2});
      chk(rdy_seen == 0, "R10 ready during second write", rdy_seen, 0);
    end
  endtask

  task automatic end_stream();
    @(negedge clk);
    stream_on = 1'b0;
    repeat (4) @(negedge clk);
    chk(pix_ready == 1'b0, "R12 ready after stream end", pix_ready, 0);
    chk(lcd_wr_n == 1'b1, "R12 strobe after stream end", lcd_wr_n, 1);
  endtask

  task automatic t_reset();
    chk(lcd_wr_n == 1'b1, "R12 reset strobe", lcd_wr_n, 1);
    chk(pix_ready == 1'b0, "R12 reset ready", pix_ready, 0);
  endtask

  task automatic t_mode16();
    open_window(1'b0, 16'h0123, 16'h01DF, 16'h0004, 16'h010F);
    chk_win("R1 R2 R8 window framing", 16'h0123, 16'h01DF, 16'h0004, 16'h010F);
    send_pix(2'd0, 24'h00F81F, 1, "R4 565 passthrough", 16'hF81F, 16'h0);
    send_pix(2'd2, 24'h123456, 1, "R3 888 to 565", 16'h11AA, 16'h0);
    send_pix(2'd1, 24'h02A57F, 1, "R3 666 to 565", 16'hAABF, 16'h0);
    end_stream();
  endtask

  task automatic t_mode18();
    open_window(1'b1, 16'h0000, 16'h031F, 16'h0100, 16'h01DF);
    chk_win("R1 R2 window framing 18-bit", 16'h0000, 16'h031F, 16'h0100, 16'h01DF);
    mode18 = 1'b0;
    send_pix(2'd2, 24'h123456, 2, "R5 R6 888 two writes", 16'h1034, 16'h0054);
    send_pix(2'd1, 24'h02A57F, 2, "R6 666 two writes", 16'hA854, 16'h00FC);
    send_pix(2'd0, 24'h008410, 2, "R7 565 msb replicate ones", 16'h8480, 16'h0084);
    send_pix(2'd0, 24'h007BEF, 2, "R7 565 msb replicate zeros", 16'h787C, 16'h0078);
    end_stream();
  endtask

  task automatic t_pending();
    int t = 0;
    open_window(1'b0, 16'h0010, 16'h0020, 16'h0030, 16'h0040);
    mon_q.delete();
    @(negedge clk);
    col_first = 16'hABCD; col_last = 16'h1234; row_first = 16'h5678; row_last = 16'h9A0B;
    win_req = 1'b1;
    @(negedge clk);
    win_req = 1'b0;
    repeat (40) @(negedge clk);
    chk(mon_q.size() == 0, "R11 no writes while request pending", mon_q.size(), 0);
    send_pix(2'd0, 24'h001234, 1, "R11 stream continues", 16'h1234, 16'h0);
    mon_q.delete();
    stream_on = 1'b0;
    wait_words(11);
    chk_win("R11 pending window framed", 16'hABCD, 16'h1234, 16'h5678, 16'h9A0B);
    repeat (6) @(negedge clk);
    while (mon_q.size() > 11 && t < 10) t++;
    chk(mon_q.size() == 11, "R2 R11 nothing after 0x2C", mon_q.size(), 11);
    end_stream();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_mode16();
    t_mode18();
    t_pending();
    chk(width_bad == 0, "R9 strobe low width", width_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule